// File: doc/BRIEF.md
# Interruption Entry and Vector Controller

This block sits next to a small processor core and takes over the control flow whenever a non-maskable event, an exception from the current instruction, or an interrupt occurs. It tracks how deeply interruptions are nested, from 0 (none active) to 3. On each accepted entry it stores the interrupted program counter together with the interrupt-enable and privilege bits in a slot for that depth. It then clears interrupt enable, forces privileged mode and issues a one-cycle redirect strobe with the handler fetch address.

The handler address is a 64 KB-aligned vector base plus an entry offset times a programmable stride. The offset comes from a fixed priority among the pending events. Two vectored modes are supported. In internal mode, seven interrupt lines are prioritised inside the block. In external mode, an outside controller hands over a 6-bit vector number through a valid/ready pair. A return pulse pops the saved state for the current depth and redirects to the saved program counter. The core can also write the interrupt-enable and privilege bits directly.

External vector handshake rules: the source raises `ext_valid` with `ext_vec` and must hold both unchanged until it sees `ext_ready` high in a cycle. A transfer happens on the rising clock edge where both are high. `ext_ready` is low whenever the vector would not be taken in that cycle. This covers a higher-priority event, interrupt enable clear, internal mode, or maximum depth. Those conditions act as back-pressure.

Top module: `intr_entry_ctrl`

## Requirements
- R1: After reset, `level` is 0, `ie_out` is 0, `priv_out` is 1, and both `redirect` and `overflow_err` are 0.
- R2: An accepted entry is visible on the clock edge after the event. At that point `level` has risen by one, `ie_out` is 0, `priv_out` is 1, and `redirect` is high for that cycle.
- R3: The entry address is `{vec_base[31:16], 16'h0} + offset * stride`. The stride is 4, 16, 64 or 256 bytes for `esz` = 0, 1, 2, 3, and the low 16 bits of `vec_base` are ignored.
- R4: `nmi` uses offset 0. An exception with `exc_kind` in 1..8 uses offset equal to `exc_kind`; any other `exc_kind` value uses offset 7.
- R5: When several events are present in one cycle, the order is `nmi`, then the exception, then the hardware interrupt, then `sw_irq`.
- R6: In internal mode (`ext_mode`=0), interrupt line k uses offset 9+k and the lowest pending index wins. `sw_irq` uses offset 15.
- R7: In external mode (`ext_mode`=1), a vector n uses offset 9+n and `ext_ready` is high in the accepting cycle. `irq_lines` are ignored, and `sw_irq` uses offset 72.
- R8: While `ie_out` is 0, `irq_lines`, `ext_valid` and `sw_irq` cause no entry and `ext_ready` stays 0.
- R9: An event at level 3 changes no level or status and gives no redirect. It sets `overflow_err`, which stays set until reset.
- R10: `eret` at level L>0 lowers the level to L-1. It restores the program counter, interrupt enable and privilege saved on the entry from L-1, and redirects to that program counter one cycle later.
- R11: `eret` at level 0 is ignored. When an event and `eret` arrive in the same cycle, the event is taken and the return is dropped.
- R12: `stat_wr_en` loads `ie_out` and `priv_out` from `stat_wr_ie` and `stat_wr_priv` on the next edge, unless an entry or return happens in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_pc | input | 32 | Program counter of the interrupted instruction |
| vec_base | input | 32 | Vector table base (low 16 bits ignored) |
| esz | input | 2 | Entry stride select |
| ext_mode | input | 1 | 1 selects external vectored mode |
| nmi | input | 1 | Non-maskable event request |
| exc_valid | input | 1 | Exception raised by the current instruction |
| exc_kind | input | 4 | Exception class, selects offset 1..8 |
| irq_lines | input | 7 | Internal-mode interrupt lines |
| ext_valid | input | 1 | External vector valid |
| ext_vec | input | 6 | External vector number |
| ext_ready | output | 1 | External vector accepted this cycle |
| sw_irq | input | 1 | Software interrupt request |
| eret | input | 1 | Return-from-interruption pulse |
| stat_wr_en | input | 1 | Status write strobe |
| stat_wr_ie | input | 1 | Interrupt-enable value to write |
| stat_wr_priv | input | 1 | Privilege value to write |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| redirect_pc | output | 32 | Handler or resume address |
| level | output | 2 | Current nesting depth |
| ie_out | output | 1 | Global interrupt enable |
| priv_out | output | 1 | Privileged mode |
| overflow_err | output | 1 | Sticky nesting overflow flag |

## Verification
The hardest state to reach is the full stack at depth 3, with three distinct saved contexts, followed by one more event. Ordinary interrupts are masked once the first entry clears the enable bit. The bench therefore climbs the levels with non-maskable events, each carrying its own program counter. It then fires a fourth event and unwinds with three returns, checking that the program counters come back in reverse order. A same-cycle exception plus return is also driven from depth 1, which shows that the event wins.

// File: rtl/intr_pkg.sv
package intr_pkg;

  // Count of fixed (non-interrupt) entries at the bottom of the vector table
  localparam int NUM_FIXED   = 9;
  localparam int OFF_NMI     = 0;
  localparam int OFF_GENERAL = 7;
  localparam int OFF_SYSCALL = 8;

  typedef struct packed {
    logic ie;
    logic priv;
  } stat_t;

  // Exception class to table offset; unknown classes fold into general
  function automatic logic [3:0] exc_offset(input logic [3:0] kind);
    if (kind >= 4'd1 && kind <= 4'(OFF_SYSCALL)) return kind;
    return 4'(OFF_GENERAL);
  endfunction

endpackage

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
#(
  parameter int INT_LINES = 7,
  parameter int EXT_VECS  = 64,
  parameter int OFF_W     = 7,
  parameter int VEC_W     = 6
) (
  input  logic                 nmi,
  input  logic                 exc_valid,
  input  logic [3:0]           exc_kind,
  input  logic [INT_LINES-1:0] irq_lines,
  input  logic                 ext_mode,
  input  logic                 ext_valid,
  input  logic [VEC_W-1:0]     ext_vec,
  input  logic                 sw_irq,
  input  logic                 ie,
  input  logic                 full,
  output logic                 take,
  output logic [OFF_W-1:0]     offset,
  output logic                 ext_ready
);

  localparam int IDX_W = (INT_LINES > 1) ? $clog2(INT_LINES) : 1;
  localparam logic [OFF_W-1:0] SW_OFF_INT = OFF_W'(NUM_FIXED + INT_LINES - 1);
  localparam logic [OFF_W-1:0] SW_OFF_EXT = OFF_W'(NUM_FIXED + EXT_VECS - 1);

  logic             irq_hit;
  logic [IDX_W-1:0] irq_idx;
  logic             hw_pend;
  logic             sw_pend;

  // lowest index wins: scan downward so the last match is the smallest
  always_comb begin
    irq_hit = 1'b0;
    irq_idx = '0;
    for (int i = INT_LINES - 1; i >= 0; i--) begin
      if (irq_lines[i]) begin
        irq_hit = 1'b1;
        irq_idx = IDX_W'(i);
      end
    end
  end

  assign hw_pend = ie && (ext_mode ? ext_valid : irq_hit);
  assign sw_pend = ie && sw_irq;
  assign take    = nmi || exc_valid || hw_pend || sw_pend;

  always_comb begin
    if (nmi)
      offset = OFF_W'(OFF_NMI);
    else if (exc_valid)
      offset = OFF_W'(exc_offset(exc_kind));
    else if (hw_pend && ext_mode)
      offset = OFF_W'(NUM_FIXED) + OFF_W'(ext_vec);
    else if (hw_pend)
      offset = OFF_W'(NUM_FIXED) + OFF_W'(irq_idx);
    else
      offset = ext_mode ? SW_OFF_EXT : SW_OFF_INT;
  end

  assign ext_ready = ext_mode && ext_valid && ie && !nmi && !exc_valid && !full;

endmodule

// File: rtl/intr_level_stack.sv
module intr_level_stack
  import intr_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int MAX_LVL = 3,
  parameter int LVL_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             eret,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic             stat_wr_en,
  input  logic             stat_wr_ie,
  input  logic             stat_wr_priv,
  output logic [LVL_W-1:0] level,
  output logic             ie,
  output logic             priv,
  output logic             full,
  output logic             do_entry,
  output logic             do_return,
  output logic [PC_W-1:0]  ret_pc,
  output logic             ovf
);

  logic [PC_W-1:0]  slot_pc   [MAX_LVL];
  stat_t            slot_stat [MAX_LVL];
  logic [LVL_W-1:0] ridx;
  stat_t            ret_stat;

  assign full      = (level == LVL_W'(MAX_LVL));
  assign do_entry  = take && !full;
  assign do_return = eret && !take && (level != '0);
  assign ridx      = level - LVL_W'(1);

  always_comb begin
    ret_pc   = '0;
    ret_stat = '0;
    for (int s = 0; s < MAX_LVL; s++) begin
      if (ridx == LVL_W'(s)) begin
        ret_pc   = slot_pc[s];
        ret_stat = slot_stat[s];
      end
    end
  end

  // one save slot per transition out of depth s
  for (genvar g = 0; g < MAX_LVL; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_pc[g]   <= '0;
        slot_stat[g] <= '0;
      end else if (do_entry && level == LVL_W'(g)) begin
        slot_pc[g]   <= cur_pc;
        slot_stat[g] <= '{ie: ie, priv: priv};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
      ie    <= 1'b0;
      priv  <= 1'b1;
      ovf   <= 1'b0;
    end else begin
      if (take && full) ovf <= 1'b1;
      if (do_entry) begin
        level <= level + LVL_W'(1);
        ie    <= 1'b0;
        priv  <= 1'b1;
      end else if (do_return) begin
        level <= level - LVL_W'(1);
        ie    <= ret_stat.ie;
        priv  <= ret_stat.priv;
      end else if (stat_wr_en) begin
        ie    <= stat_wr_ie;
        priv  <= stat_wr_priv;
      end
    end
  end

  // R2: entry masks interrupts and raises privilege
  p_entry_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_entry |=> (!ie && priv));

  // R9: a blocked event leaves the depth untouched
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && full) |=> (ovf && $stable(level)));

  // R9: overflow flag is sticky
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R11: return at depth 0 does nothing
  p_ret_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (eret && !take && level == '0) |=> (level == '0));

endmodule

// File: rtl/intr_vec_gen.sv
module intr_vec_gen #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_entry,
  input  logic             do_return,
  input  logic [OFF_W-1:0] offset,
  input  logic [PC_W-1:0]  base,
  input  logic [1:0]       esz,
  input  logic [PC_W-1:0]  ret_pc,
  output logic             redirect,
  output logic [PC_W-1:0]  redirect_pc
);

  localparam int ALIGN = 16;

  logic [3:0]      shift;
  logic [PC_W-1:0] entry_addr;
  logic            unused_base_lo;

  assign unused_base_lo = ^base[ALIGN-1:0];
  assign shift      = 4'd2 + {1'b0, esz, 1'b0};
  // largest offset << 8 stays below 64 KB, so an OR of the fields is exact
  assign entry_addr = {base[PC_W-1:ALIGN], {ALIGN{1'b0}}}
                    | (PC_W'(offset) << shift);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect    <= 1'b0;
      redirect_pc <= '0;
    end else begin
      redirect <= do_entry || do_return;
      if (do_entry)       redirect_pc <= entry_addr;
      else if (do_return) redirect_pc <= ret_pc;
    end
  end

  // R3: entry address keeps the aligned base bits
  p_base_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    do_entry |=> (redirect && redirect_pc[PC_W-1:ALIGN] == $past(base[PC_W-1:ALIGN])));

endmodule

// File: rtl/intr_entry_ctrl.sv
module intr_entry_ctrl
  import intr_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int INT_LINES = 7,
  parameter int EXT_VECS  = 64,
  parameter int MAX_LVL   = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PC_W-1:0]          cur_pc,
  input  logic [PC_W-1:0]          vec_base,
  input  logic [1:0]               esz,
  input  logic                     ext_mode,
  input  logic                     nmi,
  input  logic                     exc_valid,
  input  logic [3:0]               exc_kind,
  input  logic [INT_LINES-1:0]     irq_lines,
  input  logic                     ext_valid,
  input  logic [$clog2(EXT_VECS)-1:0] ext_vec,
  output logic                     ext_ready,
  input  logic                     sw_irq,
  input  logic                     eret,
  input  logic                     stat_wr_en,
  input  logic                     stat_wr_ie,
  input  logic                     stat_wr_priv,
  output logic                     redirect,
  output logic [PC_W-1:0]          redirect_pc,
  output logic [$clog2(MAX_LVL+1)-1:0] level,
  output logic                     ie_out,
  output logic                     priv_out,
  output logic                     overflow_err
);

  localparam int VEC_W = $clog2(EXT_VECS);
  localparam int LVL_W = $clog2(MAX_LVL + 1);
  localparam int OFF_W = $clog2(NUM_FIXED + EXT_VECS);

  logic             take;
  logic [OFF_W-1:0] offset;
  logic             full;
  logic             do_entry;
  logic             do_return;
  logic [PC_W-1:0]  ret_pc;

  intr_arbiter #(
    .INT_LINES(INT_LINES), .EXT_VECS(EXT_VECS), .OFF_W(OFF_W), .VEC_W(VEC_W)
  ) u_arb (
    .nmi       (nmi),
    .exc_valid (exc_valid),
    .exc_kind  (exc_kind),
    .irq_lines (irq_lines),
    .ext_mode  (ext_mode),
    .ext_valid (ext_valid),
    .ext_vec   (ext_vec),
    .sw_irq    (sw_irq),
    .ie        (ie_out),
    .full      (full),
    .take      (take),
    .offset    (offset),
    .ext_ready (ext_ready)
  );

  intr_level_stack #(
    .PC_W(PC_W), .MAX_LVL(MAX_LVL), .LVL_W(LVL_W)
  ) u_stack (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (take),
    .eret         (eret),
    .cur_pc       (cur_pc),
    .stat_wr_en   (stat_wr_en),
    .stat_wr_ie   (stat_wr_ie),
    .stat_wr_priv (stat_wr_priv),
    .level        (level),
    .ie           (ie_out),
    .priv         (priv_out),
    .full         (full),
    .do_entry     (do_entry),
    .do_return    (do_return),
    .ret_pc       (ret_pc),
    .ovf          (overflow_err)
  );

  intr_vec_gen #(
    .PC_W(PC_W), .OFF_W(OFF_W)
  ) u_vec (
    .clk         (clk),
    .rst_n       (rst_n),
    .do_entry    (do_entry),
    .do_return   (do_return),
    .offset      (offset),
    .base        (vec_base),
    .esz         (esz),
    .ret_pc      (ret_pc),
    .redirect    (redirect),
    .redirect_pc (redirect_pc)
  );

  // R8: with interrupts masked only non-maskable sources or returns redirect
  p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_out && !nmi && !exc_valid && !eret) |=> !redirect);

  // R2: depth moves by at most one per cycle
  p_level_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level == $past(level) || level == $past(level) + LVL_W'(1)
              || level == $past(level) - LVL_W'(1)));

endmodule

// File: tb/tb_intr_entry_ctrl.sv
module tb_intr_entry_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cur_pc = '0, vec_base = '0;
  logic [1:0]  esz = '0;
  logic        ext_mode = 0, nmi = 0, exc_valid = 0;
  logic [3:0]  exc_kind = '0;
  logic [6:0]  irq_lines = '0;
  logic        ext_valid = 0;
  logic [5:0]  ext_vec = '0;
  logic        ext_ready;
  logic        sw_irq = 0, eret = 0, stat_wr_en = 0, stat_wr_ie = 0, stat_wr_priv = 0;
  logic        redirect;
  logic [31:0] redirect_pc;
  logic [1:0]  level;
  logic        ie_out, priv_out, overflow_err;

  int checks = 0;
  int errors = 0;

  localparam logic [31:0] BASE = 32'h1234_ABCD;
  localparam logic [31:0] BHI  = 32'h1234_0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  intr_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .vec_base(vec_base), .esz(esz),
    .ext_mode(ext_mode), .nmi(nmi), .exc_valid(exc_valid), .exc_kind(exc_kind),
    .irq_lines(irq_lines), .ext_valid(ext_valid), .ext_vec(ext_vec),
    .ext_ready(ext_ready), .sw_irq(sw_irq), .eret(eret), .stat_wr_en(stat_wr_en),
    .stat_wr_ie(stat_wr_ie), .stat_wr_priv(stat_wr_priv), .redirect(redirect),
    .redirect_pc(redirect_pc), .level(level), .ie_out(ie_out), .priv_out(priv_out),
    .overflow_err(overflow_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input int off, input int sz);
    return BHI + 32'(off << (2 + 2 * sz));
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    nmi = 0; exc_valid = 0; exc_kind = '0; irq_lines = '0; ext_valid = 0;
    sw_irq = 0; eret = 0; stat_wr_en = 0;
  endtask

  task automatic set_status(input logic i, input logic p);
    stat_wr_en = 1; stat_wr_ie = i; stat_wr_priv = p;
    tick();
    stat_wr_en = 0;
  endtask

  task automatic do_ret(input string req, input logic [31:0] pc, input logic [1:0] lvl);
    eret = 1;
    tick();
    check({req, " return redirect"}, 32'(redirect), 32'd1);
    check({req, " return pc"}, redirect_pc, pc);
    check({req, " return level"}, 32'(level), 32'(lvl));
    clear_inputs();
  endtask

  task automatic test_reset();
    check("R1 level", 32'(level), 0);
    check("R1 ie", 32'(ie_out), 0);
    check("R1 priv", 32'(priv_out), 1);
    check("R1 redirect", 32'(redirect), 0);
    check("R1 overflow", 32'(overflow_err), 0);
  endtask

  task automatic test_entry_return();
    set_status(1, 0);
    check("R12 ie written", 32'(ie_out), 1);
    check("R12 priv written", 32'(priv_out), 0);
    cur_pc = 32'h100; esz = 0; exc_valid = 1; exc_kind = 4'd2;
    tick();
    check("R2 redirect", 32'(redirect), 1);
    check("R4 R3 addr kind2", redirect_pc, exp_addr(2, 0));
    check("R2 level", 32'(level), 1);
    check("R2 ie cleared", 32'(ie_out), 0);
    check("R2 priv set", 32'(priv_out), 1);
    clear_inputs();
    tick();
    check("R2 redirect one cycle", 32'(redirect), 0);
    do_ret("R10", 32'h100, 0);
    check("R10 ie restored", 32'(ie_out), 1);
    check("R10 priv restored", 32'(priv_out), 0);
    eret = 1;
    tick();
    check("R11 ret at level0 no redirect", 32'(redirect), 0);
    check("R11 ret at level0 level", 32'(level), 0);
    clear_inputs();
  endtask

  task automatic test_stride();
    for (int s = 0; s < 4; s++) begin
      esz = 2'(s); cur_pc = 32'h200 + 32'(s); exc_valid = 1; exc_kind = 4'd8;
      tick();
      check($sformatf("R3 stride esz=%0d", s), redirect_pc, exp_addr(8, s));
      clear_inputs();
      do_ret("R10", 32'h200 + 32'(s), 0);
    end
    esz = 0; exc_valid = 1; exc_kind = 4'd12;
    tick();
    check("R4 unknown kind to general", redirect_pc, exp_addr(7, 0));
    clear_inputs();
    do_ret("R10", 32'h203, 0);
  endtask

  task automatic test_priority();
    esz = 0; cur_pc = 32'h300;
    nmi = 1; exc_valid = 1; exc_kind = 4'd3; irq_lines = 7'h7f; sw_irq = 1;
    tick();
    check("R5 nmi first", redirect_pc, exp_addr(0, 0));
    clear_inputs();
    do_ret("R10", 32'h300, 0);
    exc_valid = 1; exc_kind = 4'd3; irq_lines = 7'h7f; sw_irq = 1;
    tick();
    check("R5 exception over irq", redirect_pc, exp_addr(3, 0));
    clear_inputs();
    do_ret("R10", 32'h300, 0);
    irq_lines = 7'b1010100; sw_irq = 1;
    tick();
    check("R6 lowest line wins", redirect_pc, exp_addr(11, 0));
    check("R6 ie cleared", 32'(ie_out), 0);
    clear_inputs();
    do_ret("R10", 32'h300, 0);
    sw_irq = 1;
    tick();
    check("R6 sw internal offset", redirect_pc, exp_addr(15, 0));
    clear_inputs();
    do_ret("R10", 32'h300, 0);
  endtask

  task automatic test_masked();
    set_status(0, 0);
    irq_lines = 7'h7f; sw_irq = 1;
    tick();
    check("R8 masked no redirect", 32'(redirect), 0);
    check("R8 masked level", 32'(level), 0);
    clear_inputs();
    ext_mode = 1; ext_valid = 1; ext_vec = 6'd5;
    #1;
    check("R8 masked ready low", 32'(ext_ready), 0);
    tick();
    check("R8 masked ext no redirect", 32'(redirect), 0);
    clear_inputs();
    ext_mode = 0;
    set_status(1, 0);
  endtask

  task automatic test_external();
    ext_mode = 1; esz = 1; cur_pc = 32'h400;
    ext_valid = 1; ext_vec = 6'd40; irq_lines = 7'h7f;
    #1;
    check("R7 ready when accepted", 32'(ext_ready), 1);
    tick();
    check("R7 ext offset", redirect_pc, exp_addr(49, 1));
    check("R7 level", 32'(level), 1);
    clear_inputs();
    do_ret("R10", 32'h400, 0);
    esz = 3; sw_irq = 1;
    tick();
    check("R7 sw external offset", redirect_pc, exp_addr(72, 3));
    clear_inputs();
    do_ret("R10", 32'h400, 0);
    ext_mode = 0; esz = 0;
  endtask

  task automatic test_nesting();
    for (int i = 0; i < 3; i++) begin
      cur_pc = 32'h1000 + 32'(4 * i); nmi = 1;
      tick();
      check("R2 nest level", 32'(level), 32'(i + 1));
      clear_inputs();
    end
    cur_pc = 32'h2000; nmi = 1;
    tick();
    check("R9 no redirect at full", 32'(redirect), 0);
    check("R9 level held", 32'(level), 3);
    check("R9 overflow set", 32'(overflow_err), 1);
    clear_inputs();
    do_ret("R10", 32'h1008, 2);
    do_ret("R10", 32'h1004, 1);
    do_ret("R10", 32'h1000, 0);
    check("R10 ie after unwind", 32'(ie_out), 1);
    check("R9 overflow sticky", 32'(overflow_err), 1);
  endtask

  task automatic test_event_with_return();
    cur_pc = 32'h500; exc_valid = 1; exc_kind = 4'd1;
    tick();
    clear_inputs();
    cur_pc = 32'h504; exc_valid = 1; exc_kind = 4'd5; eret = 1;
    tick();
    check("R11 event wins level", 32'(level), 2);
    check("R11 event wins addr", redirect_pc, exp_addr(5, 0));
    clear_inputs();
    do_ret("R10", 32'h504, 1);
    do_ret("R10", 32'h500, 0);
  endtask

  initial begin
    vec_base = BASE;
    repeat (3) tick();
    rst_n = 1;
    tick();
    test_reset();
    test_entry_return();
    test_stride();
    test_priority();
    test_masked();
    test_external();
    test_event_with_return();
    test_nesting();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule